// File: doc/BRIEF.md
# Periodic Refresh Interval Timer

This block is a down-counting interval timer that runs on the external bus clock. Its usual job is to time periodic DRAM refresh requests, and it can also raise a periodic interrupt. Software loads a count through a timer write strobe and loads a reload value through a preload write strobe. Both strobes share one data bus. A separate enable input starts and stops counting.

While enabled, the timer counts down once per clock. A cycle in which the count is zero is a terminal cycle. In that cycle the counter takes the reload value instead of decrementing, and the block drives its active-low overflow output. Bit 31 of the preload word sets the pulse width. When it is 0 the pulse is one clock wide, which suits a refresh requester. When it is 1 the pulse is three clocks wide, so an edge-sensitive interrupt input can catch it. The timer keeps running from the reload value without any software action.

Top module: `refresh_interval_timer`

## Requirements
- R1: After reset the overflow output `ovf_n` is high. The count and the preload value are zero and the preload selects the one-clock width, so enabling the timer with no writes gives a terminal cycle at once and on every clock after it.
- R2: While `run_en` is 1 and no timer write happens, the count decreases by one per clock. A clock in which the count is 0 is a terminal cycle, and `ovf_n` is low in the clock after it.
- R3: With preload bit 31 = 0, each terminal cycle drives `ovf_n` low for exactly one clock.
- R4: With preload bit 31 = 1, each terminal cycle drives `ovf_n` low for exactly three consecutive clocks.
- R5: In a terminal cycle the count reloads from preload bits 30:0, so terminal cycles repeat every preload+1 clocks.
- R6: A timer write (`cnt_wr` = 1) loads `wr_data` bits 30:0 into the count at the next clock edge. It overrides counting in that clock, and that clock is never a terminal cycle. Bit 31 of a timer write is ignored.
- R7: A preload write (`rld_wr` = 1) stores `wr_data` bits 30:0 as the reload value and bit 31 as the width select. It does not change the running count, so it takes effect at the next reload.
- R8: While `run_en` is 0 the count holds its value. `ovf_n` is high from the clock after `run_en` falls, which cuts short any pulse in progress.
- R9: A preload of zero with the one-clock width holds `ovf_n` low on every clock. With the three-clock width, a terminal cycle that comes while a pulse is still low extends the low level rather than starting a separate pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Timer on/off; counting runs only while this is 1 |
| cnt_wr | input | 1 | Timer register write strobe |
| rld_wr | input | 1 | Preload register write strobe |
| wr_data | input | 32 | Write data shared by both strobes; bit 31 is the width select for preload writes |
| ovf_n | output | 1 | Overflow pulse, active low |

## Verification
Two cases are the hardest to reach from the ports. One is a three-clock pulse that is cut short: this needs the count placed so a terminal cycle falls just before `run_en` drops. The other is a terminal cycle that lands while the previous pulse is still low: this needs a reload value of one with the wide width. The stimulus first writes a small preload and then a small timer value, so both cases occur within a few clocks. It then compares every clock against a pulse train computed from the terminal-cycle index, the period and the width. A frozen-count run checks that the terminal cycle moves later by exactly the number of disabled clocks. Timer and preload writes made mid-run show whether each value acts at once or only at the next reload.

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int DATA_W   = 32,
  parameter int WIDE_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              cnt_wr,
  input  logic              rld_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ovf_n
);

  localparam int CW = DATA_W - 1;
  localparam int SW = (WIDE_LEN > 2) ? $clog2(WIDE_LEN) : 1;
  localparam logic [SW-1:0] HOLD_INIT = SW'(WIDE_LEN - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] rld;
  logic          wide;
  logic [SW-1:0] hold;
  logic          ovf_q;

  wire at_zero = (cnt == '0);
  wire hit     = run_en && !cnt_wr && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld  <= '0;
      wide <= 1'b0;
    end else if (rld_wr) begin
      rld  <= wr_data[CW-1:0];
      wide <= wr_data[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_wr)
      cnt <= wr_data[CW-1:0];
    else if (run_en)
      cnt <= at_zero ? rld : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= '0;
      ovf_q <= 1'b1;
    end else if (!run_en) begin
      hold  <= '0;
      ovf_q <= 1'b1;
    end else if (hit) begin
      hold  <= wide ? HOLD_INIT : '0;
      ovf_q <= 1'b0;
    end else if (hold != '0) begin
      hold  <= hold - 1'b1;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b1;
    end
  end

  assign ovf_n = ovf_q;

  AST_FELL_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_n) |-> $past(run_en && !cnt_wr && cnt == '0)); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ovf_n); // R8

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> $stable(cnt)); // R8

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_wr && cnt == '0) |=> cnt == $past(rld)); // R5

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wr_data[CW-1:0])); // R6

  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && hold != '0) |=> !ovf_n); // R4

  AST_NARROW_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_n && hold == '0 && !(run_en && !cnt_wr && cnt == '0)) |=> ovf_n); // R3

endmodule

// File: tb/refresh_interval_timer_bench.sv
module refresh_interval_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        cnt_wr = 1'b0;
  logic        rld_wr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ovf_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  refresh_interval_timer u_refresh_interval_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_wr(cnt_wr),
    .rld_wr(rld_wr), .wr_data(wr_data), .ovf_n(ovf_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_low(int i, int first, int period, int width);
    if (i < first) return 1'b0;
    if (period < width) return 1'b1;
    return ((i - first) % period) < width;
  endfunction

  task automatic chk(logic act, logic exp, string tag, int idx);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s clock %0d: ovf_n=%b expected %b", tag, idx, act, exp);
    end
  endtask

  task automatic observe(int from, int to, int first, int period, int width, string tag);
    for (int i = from; i <= to; i++) begin
      @(negedge clk);
      cnt_wr = 1'b0;
      rld_wr = 1'b0;
      chk(ovf_n, !exp_low(i, first, period, width), tag, i);
    end
  endtask

  task automatic start(logic [30:0] cv, logic [30:0] rv, logic wide);
    @(negedge clk);
    cnt_wr = 1'b0;
    run_en = 1'b0;
    rld_wr = 1'b1;
    wr_data = {wide, rv};
    @(negedge clk);
    rld_wr = 1'b0;
    cnt_wr = 1'b1;
    wr_data = {1'b0, cv};
    run_en = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(ovf_n, 1'b1, "R1 reset level", 0);
    run_en = 1'b1;
    observe(0, 3, 0, 1, 1, "R1 reset count and preload zero");
  endtask

  task automatic t_narrow;
    start(31'd5, 31'd3, 1'b0);
    observe(0, 20, 6, 4, 1, "R2 R3 R5 narrow train");
  endtask

  task automatic t_wide;
    start(31'd3, 31'd6, 1'b1);
    observe(0, 25, 4, 7, 3, "R4 wide train");
  endtask

  task automatic t_zero_narrow;
    start(31'd0, 31'd0, 1'b0);
    observe(0, 10, 1, 1, 1, "R9 zero preload narrow");
  endtask

  task automatic t_overlap;
    start(31'd0, 31'd1, 1'b1);
    observe(0, 12, 1, 2, 3, "R9 wide overlap extends");
  endtask

  task automatic t_freeze;
    start(31'd10, 31'd20, 1'b0);
    observe(0, 3, 11, 21, 1, "R8 before freeze");
    run_en = 1'b0;
    observe(4, 8, 1000, 21, 1, "R8 frozen");
    run_en = 1'b1;
    observe(9, 20, 16, 21, 1, "R8 resumed count held");
  endtask

  task automatic t_cut;
    start(31'd2, 31'd50, 1'b1);
    observe(0, 3, 3, 51, 3, "R8 pulse begins");
    run_en = 1'b0;
    observe(4, 7, 1000, 51, 3, "R8 pulse cut short");
  endtask

  task automatic t_preload_late;
    start(31'd3, 31'd3, 1'b0);
    observe(0, 1, 4, 4, 1, "R7 before preload write");
    rld_wr = 1'b1;
    wr_data = 32'd9;
    observe(2, 30, 4, 10, 1, "R7 preload at next reload");
  endtask

  task automatic t_timer_write;
    start(31'd20, 31'd2, 1'b0);
    observe(0, 2, 21, 3, 1, "R6 before timer write");
    cnt_wr = 1'b1;
    wr_data = 32'h8000_0004;
    observe(3, 15, 8, 3, 1, "R6 immediate load bit31 ignored");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ovf_n, 1'b1, "R1 during reset", 0);
    rst_n = 1'b1;
    t_reset();
    t_narrow();
    t_wide();
    t_zero_narrow();
    t_overlap();
    t_freeze();
    t_cut();
    t_preload_late();
    t_timer_write();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule